// File: doc/BRIEF.md
# Key Change Run-Length Event Logger

This block watches a bank of 21 binary inputs (twenty key switches and one synchronizer line) and records them in compressed form. On every periodic tick (nominally every 0.1 s) all inputs are captured together, and any combination of them may be active. Only changes are recorded. When a captured pattern differs from the one before it, the block stores the old pattern together with the number of ticks it was held. The run-length counter then starts again at one.

Entries go into a 256-byte internal buffer. A consumer reads the buffer through a registered read port when the block raises a flush request, which it does once 176 bytes are held. Writing continues at the tail while the flush is in progress. The consumer empties the buffer with an acknowledge pulse. A run longer than the 8-bit counter can hold produces extra overflow entries. Dropping the enable input closes the session: the pending run is written out and an end-of-data flag is raised.

Top module: `keylog_top`

## Requirements
- R1: While `en` is low, ticks are ignored: no entry is written and the buffer contents and fill count stay unchanged.
- R2: The first tick after `en` rises only captures the reference pattern and writes nothing; the run length then stands at one.
- R3: When a tick captures a pattern that differs from the reference, one 4-byte entry is written at consecutive addresses starting at the current fill count. The bytes are, in order: pattern bits 7:0, pattern bits 15:8, pattern bits 20:16 with the upper three bits zero, and then the run length.
- R4: The run length stored for a pattern equals the number of ticks on which that pattern was captured, counting from the tick that first captured it. After a change the counter restarts at one.
- R5: When a tick with no change arrives while the run length is 255, an overflow entry is written (the current pattern followed by a run-length byte of 0x00) and the counter restarts at one.
- R6: When `en` falls while a session is active, a final entry holding the reference pattern and its pending run length is written and `end_of_data` goes high. `end_of_data` stays high until `en` is high again.
- R7: `flush_req` is high exactly when `fill_count` is 176 or more. Entries keep being appended while it is high.
- R8: `fill_count` equals the number of bytes stored, up to 256. Bytes that arrive when the buffer is full are discarded, stored bytes are left unchanged, and the `overrun` flag goes high and stays high.
- R9: A `flush_ack` pulse sets `fill_count` to zero and clears `overrun` and `flush_req`. The next entry starts at address 0.
- R10: `rd_data` shows the byte stored at `rd_addr` one clock after the address is presented.
- R11: After reset `fill_count`, `flush_req`, `overrun` and `end_of_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Session enable (timer switch) |
| tick | input | 1 | One-cycle sampling strobe |
| keys | input | 21 | Key and synchronizer inputs |
| flush_ack | input | 1 | Consumer has drained the buffer; empty it |
| rd_addr | input | 8 | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr, registered |
| fill_count | output | 9 | Bytes currently stored |
| flush_req | output | 1 | Buffer at or above the flush threshold |
| overrun | output | 1 | Sticky: a byte was dropped because the buffer was full |
| end_of_data | output | 1 | Session closed and final entry written |

## Verification
A wrong reference pattern or run-length counter does not show up at once. It appears in the next entry that is written, at the latest one tick after a change, and within four clocks of that tick. The bench therefore reads back every stored byte after each phase and compares it with the entry stream it derived independently. A wrong fill pointer shows within four clocks of the tick that caused it, either as a wrong `fill_count` or as a wrong `flush_req` edge around 172 to 176 bytes. A broken full or overrun path shows up as changed bytes or a missing sticky flag once the buffer passes 256 bytes.

// File: rtl/keylog_pkg.sv
package keylog_pkg;
  localparam int BYTE_W  = 8;
  localparam int DUR_W   = 8;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  typedef enum logic [1:0] {
    EV_CHANGE   = 2'd0,
    EV_OVERFLOW = 2'd1,
    EV_FINAL    = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/keylog_sampler.sv
module keylog_sampler
  import keylog_pkg::*;
#(
  parameter int NKEYS = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [NKEYS-1:0] keys,
  output logic             ev_valid,
  output ev_kind_t         ev_kind,
  output logic [NKEYS-1:0] ev_pat,
  output logic [DUR_W-1:0] ev_dur,
  output logic             eod
);
  logic             armed;
  logic [NKEYS-1:0] ref_q;
  logic [DUR_W-1:0] dur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      ref_q    <= '0;
      dur_q    <= '0;
      ev_valid <= 1'b0;
      ev_kind  <= EV_CHANGE;
      ev_pat   <= '0;
      ev_dur   <= '0;
      eod      <= 1'b0;
    end else begin
      ev_valid <= 1'b0;
      if (!en) begin
        if (armed) begin
          ev_valid <= 1'b1;
          ev_kind  <= EV_FINAL;
          ev_pat   <= ref_q;
          ev_dur   <= dur_q;
          armed    <= 1'b0;
          eod      <= 1'b1;
        end
      end else begin
        eod <= 1'b0;
        if (tick) begin
          if (!armed) begin
            armed <= 1'b1;
            ref_q <= keys;
            dur_q <= DUR_W'(1);
          end else if (keys != ref_q) begin
            ev_valid <= 1'b1;
            ev_kind  <= EV_CHANGE;
            ev_pat   <= ref_q;
            ev_dur   <= dur_q;
            ref_q    <= keys;
            dur_q    <= DUR_W'(1);
          end else if (dur_q == DUR_MAX) begin
            ev_valid <= 1'b1;
            ev_kind  <= EV_OVERFLOW;
            ev_pat   <= ref_q;
            ev_dur   <= dur_q;
            dur_q    <= DUR_W'(1);
          end else begin
            dur_q <= dur_q + DUR_W'(1);
          end
        end
      end
    end
  end

  AST_DUR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    armed |-> (dur_q != '0));  // R4

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> !ev_valid);  // R2

  AST_FINAL_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $fell(armed) |-> (ev_valid && ev_kind == EV_FINAL && eod));  // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!armed && !$past(armed)) |-> !ev_valid);  // R1
endmodule

// File: rtl/keylog_packer.sv
module keylog_packer
  import keylog_pkg::*;
#(
  parameter int NKEYS = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  ev_kind_t          ev_kind,
  input  logic [NKEYS-1:0]  ev_pat,
  input  logic [DUR_W-1:0]  ev_dur,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int PAT_BYTES   = (NKEYS + BYTE_W - 1) / BYTE_W;
  localparam int PAT_W       = PAT_BYTES * BYTE_W;
  localparam int ENTRY_BYTES = PAT_BYTES + 1;
  localparam int SW          = ENTRY_BYTES * BYTE_W;
  localparam int LW          = $clog2(ENTRY_BYTES + 1);

  logic [PAT_W-1:0]  pat_pad;
  logic [DUR_W-1:0]  dur_byte;
  logic [SW-1:0]     sh_q;
  logic [LW-1:0]     left_q;

  generate
    if (PAT_W > NKEYS) begin : g_pad
      assign pat_pad = {{(PAT_W - NKEYS){1'b0}}, ev_pat};
    end else begin : g_exact
      assign pat_pad = ev_pat;
    end
  endgenerate

  assign dur_byte = (ev_kind == EV_OVERFLOW) ? '0 : ev_dur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (ev_valid) begin
      sh_q   <= {dur_byte, pat_pad};
      left_q <= LW'(ENTRY_BYTES);
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> BYTE_W;
      left_q <= left_q - LW'(1);
    end
  end

  assign wr_valid = (left_q != '0);
  assign wr_data  = sh_q[BYTE_W-1:0];

  AST_NO_EVENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |-> !ev_valid);  // R3

  AST_ENTRY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> (left_q == LW'(ENTRY_BYTES)));  // R3
endmodule

// File: rtl/keylog_buffer.sv
module keylog_buffer
  import keylog_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int THRESH = 176,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flush_ack,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CW-1:0]     fill_count,
  output logic              flush_req,
  output logic              overrun
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CW-1:0]     base;
  logic              room;
  logic              do_wr;
  logic [CW-1:0]     fill_n;
  logic              ovr_n;

  always_comb begin
    base   = flush_ack ? '0 : fill_count;
    room   = (base < CW'(DEPTH));
    do_wr  = wr_valid && room;
    fill_n = base + CW'(do_wr);
    ovr_n  = (flush_ack ? 1'b0 : overrun) | (wr_valid && !room);
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[base[AW-1:0]] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_count <= '0;
      flush_req  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      fill_count <= fill_n;
      flush_req  <= (fill_n >= CW'(THRESH));
      overrun    <= ovr_n;
    end
  end

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CW'(DEPTH));  // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !flush_ack) |=> overrun);  // R8

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fill_count == CW'(DEPTH) && !flush_ack) |=> (fill_count == CW'(DEPTH)));  // R8

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_ack |=> (fill_count <= CW'(1) && !overrun));  // R9

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!flush_ack && !wr_valid) |=> $stable(fill_count));  // R1
endmodule

// File: rtl/keylog_top.sv
module keylog_top
  import keylog_pkg::*;
#(
  parameter int NKEYS  = 21,
  parameter int DEPTH  = 256,
  parameter int THRESH = 176,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [NKEYS-1:0]  keys,
  input  logic              flush_ack,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CW-1:0]     fill_count,
  output logic              flush_req,
  output logic              overrun,
  output logic              end_of_data
);
  logic              ev_valid;
  ev_kind_t          ev_kind;
  logic [NKEYS-1:0]  ev_pat;
  logic [DUR_W-1:0]  ev_dur;
  logic              wr_valid;
  logic [BYTE_W-1:0] wr_data;

  keylog_sampler #(.NKEYS(NKEYS)) u_sampler (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .keys(keys),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_pat(ev_pat),
    .ev_dur(ev_dur), .eod(end_of_data)
  );

  keylog_packer #(.NKEYS(NKEYS)) u_packer (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_pat(ev_pat), .ev_dur(ev_dur),
    .wr_valid(wr_valid), .wr_data(wr_data)
  );

  keylog_buffer #(.DEPTH(DEPTH), .THRESH(THRESH), .AW(AW), .CW(CW)) u_buffer (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .flush_ack(flush_ack), .rd_addr(rd_addr), .rd_data(rd_data),
    .fill_count(fill_count), .flush_req(flush_req), .overrun(overrun)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (fill_count == '0 && !flush_req && !overrun && !end_of_data));  // R11
endmodule

// File: tb/tb_keylog_top.sv
module tb_keylog_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic [20:0] keys = '0;
  logic        flush_ack = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [8:0]  fill_count;
  logic        flush_req;
  logic        overrun;
  logic        end_of_data;

  int checks = 0;
  int errors = 0;

  logic [7:0]  exp_mem [256];
  int          exp_fill = 0;
  bit          exp_ovr = 0;
  bit          exp_eod = 0;
  bit          m_armed = 0;
  logic [20:0] m_ref = '0;
  int          m_dur = 0;

  always #5 clk = ~clk;

  keylog_top dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .keys(keys),
    .flush_ack(flush_ack), .rd_addr(rd_addr), .rd_data(rd_data),
    .fill_count(fill_count), .flush_req(flush_req), .overrun(overrun),
    .end_of_data(end_of_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    if (exp_fill < 256) begin
      exp_mem[exp_fill] = b;
      exp_fill++;
    end else begin
      exp_ovr = 1;
    end
  endtask

  task automatic push_entry(input logic [20:0] p, input int d);
    push_byte(p[7:0]);
    push_byte(p[15:8]);
    push_byte({3'b000, p[20:16]});
    push_byte(8'(d));
  endtask

  task automatic do_tick(input logic [20:0] p);
    @(negedge clk);
    keys = p;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (7) @(negedge clk);
    if (en) begin
      if (!m_armed) begin
        m_armed = 1; m_ref = p; m_dur = 1;
      end else if (p != m_ref) begin
        push_entry(m_ref, m_dur); m_ref = p; m_dur = 1;
      end else if (m_dur == 255) begin
        push_entry(m_ref, 0); m_dur = 1;
      end else begin
        m_dur++;
      end
    end
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en = v;
    repeat (8) @(negedge clk);
    if (!v && m_armed) begin
      push_entry(m_ref, m_dur); m_armed = 0; exp_eod = 1;
    end
    if (v) exp_eod = 0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
    repeat (2) @(negedge clk);
    exp_fill = 0;
    exp_ovr = 0;
  endtask

  task automatic read_byte(input int a, output logic [7:0] b);
    @(negedge clk);
    rd_addr = 8'(a);
    @(negedge clk);
    b = rd_data;
  endtask

  task automatic check_status(input string req);
    chk({req, " fill_count"}, int'(fill_count), exp_fill);
    chk({req, " flush_req"}, int'(flush_req), (exp_fill >= 176) ? 1 : 0);
    chk({req, " overrun"}, int'(overrun), int'(exp_ovr));
    chk({req, " end_of_data"}, int'(end_of_data), int'(exp_eod));
  endtask

  task automatic verify_mem(input string req);
    logic [7:0] b;
    for (int i = 0; i < exp_fill; i++) begin
      read_byte(i, b);
      chk({req, " byte"}, int'(b), int'(exp_mem[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [20:0] pa;
    int          f0;
    int          t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_status("R11 reset");

    // R1: ticks while disabled leave everything alone
    do_tick(21'h1ABCDE);
    do_tick(21'h000001);
    check_status("R1 disabled ticks");

    // R2: arming tick writes nothing
    set_en(1'b1);
    do_tick(21'h000000);
    check_status("R2 arm tick");

    // R3 R4: walking single keys with varied hold lengths
    for (int k = 0; k < 21; k++) begin
      for (int h = 0; h <= k % 3; h++) do_tick(21'(1) << k);
    end
    do_tick(21'h1FFFFF); do_tick(21'h1FFFFF);
    do_tick(21'h0AAAAA);
    for (int h = 0; h < 4; h++) do_tick(21'h155555);
    check_status("R3 walk");
    verify_mem("R3 R4 walk entries");

    // R5: a run of 300 ticks gives one overflow entry then 45
    do_tick(21'h100001);
    f0 = exp_fill;
    for (int h = 0; h < 299; h++) do_tick(21'h100001);
    do_tick(21'h000000);
    read_byte(f0, b);     chk("R5 overflow pat lo", int'(b), 8'h01);
    read_byte(f0 + 2, b); chk("R5 overflow pat hi", int'(b), 8'h10);
    read_byte(f0 + 3, b); chk("R5 overflow dur", int'(b), 0);
    read_byte(f0 + 7, b); chk("R4 remainder dur", int'(b), 45);
    check_status("R5 after overflow");

    // R7: threshold boundary and appending while flush is requested
    t = 0;
    while (exp_fill < 172) begin
      t++;
      do_tick(21'(t * 37 + 3));
    end
    check_status("R7 below threshold");
    chk("R7 flush low at 172", int'(flush_req), 0);
    t++; do_tick(21'(t * 37 + 3));
    chk("R7 flush high at 176", int'(flush_req), 1);
    t++; do_tick(21'(t * 37 + 3));
    check_status("R7 append during flush");

    // R6: closing the session writes the final run
    do_tick(21'(t * 37 + 3));
    set_en(1'b0);
    check_status("R6 close");
    chk("R6 end_of_data", int'(end_of_data), 1);
    do_tick(21'h0F0F0F);
    check_status("R1 ticks after close");
    verify_mem("R3 R6 R10 full readback");

    // R9: acknowledge empties; next entry lands at address 0
    do_ack();
    check_status("R9 after ack");
    set_en(1'b1);
    check_status("R6 eod cleared");
    do_tick(21'h000005);
    do_tick(21'h000006);
    read_byte(0, b); chk("R9 addr0 pattern", int'(b), 5);
    read_byte(3, b); chk("R9 addr3 duration", int'(b), 1);
    check_status("R9 first entry");

    // R8: fill past capacity
    pa = 21'h000006;
    while (exp_fill < 256 || !exp_ovr) begin
      pa = pa ^ 21'h12345;
      do_tick(pa);
    end
    do_tick(pa ^ 21'h1);
    check_status("R8 overrun");
    verify_mem("R8 contents kept");
    do_ack();
    check_status("R9 overrun cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule